// File: doc/BRIEF.md
# Four-Stream Prioritized DMA Controller

This block moves data between peripherals and memory on behalf of four independent streams. Software programs each stream through a small register slave port with a source address, a destination address, a byte count and a control word. A single bus master port then carries all of the data. It handles one transfer at a time and waits for an acknowledge or an error response before it issues the next.

When several streams are ready, a fixed-priority arbiter chooses the lowest-numbered one. The chosen stream runs one burst of at most 64 bytes, which is the capacity of a shared 16-word FIFO. The burst first fills the FIFO with reads at the source size and then drains it with writes at the destination size. The FIFO works on bytes, so byte, halfword and word sizes can be combined in any way. After each burst the arbiter runs again. A peripheral stream is ready while its request input is high. Stream 3 can also be set to memory-to-memory mode, in which it runs without a request.

When a stream finishes or receives an error response, it clears its enable bit and sets a status bit. Each status bit drives its own level interrupt until software writes a one to clear it.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset every stream's control, status and count registers read zero, the master request is low and all interrupts are low.
- R2: The register address is {stream[1:0], reg[2:0]}. The registers are 0 source, 1 destination, 2 remaining byte count, 3 control, 4 status, 5 current source and 6 current destination. Registers 0 to 3 read back the value written to them.
- R3: A stream that is not in memory-to-memory mode issues no master request while its request input is low.
- R4: When several streams are ready at a burst boundary, the lowest-numbered one is granted. A memory-to-memory stream 3 yields to a requesting stream 0 at its next burst boundary.
- R5: Control bits are: bit0 enable, bits2:1 source size, bits4:3 destination size (0 = byte, 1 = halfword, 2 or 3 = word), bit5 source increment, bit6 destination increment and bit7 memory-to-memory. An address with its increment bit set advances by its own size after each transfer; otherwise it stays fixed. Writing enable copies source and destination into the current-address registers.
- R6: Bus data is right-justified and little-endian. The bytes reach the destination in the order they were read from the source, whatever the two sizes are.
- R7: A burst moves min(remaining count, 64) bytes and is never interrupted: all its reads come first, then all its writes. Exactly count bytes are written in total.
- R8: When the remaining count reaches zero, the stream clears enable and sets status bit0, and its done interrupt goes high. Writing a one to status bit0 clears both.
- R9: An error response on the master port clears the stream's enable and sets status bit1, which raises its error interrupt. The stream then issues no further requests.
- R10: The memory-to-memory bit exists only on stream 3. On streams 0 to 2 it reads as zero, and such a stream still waits for its request input.
- R11: After completion, current source and current destination hold the start addresses advanced by the count, or unchanged when the address is fixed.
- R12: While a master request is waiting for its response, the address, direction and size stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address {stream, reg} |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| dreq_i | input | 4 | Per-stream peripheral request |
| m_req_o | output | 1 | Master transfer request, held until response |
| m_we_o | output | 1 | Master direction, 1 = write |
| m_addr_o | output | AW | Master byte address |
| m_size_o | output | 2 | Master transfer size code |
| m_wdata_o | output | 32 | Master write data, right-justified |
| m_rdata_i | input | 32 | Master read data, right-justified |
| m_ack_i | input | 1 | Master transfer completed |
| m_err_i | input | 1 | Master transfer error response |
| irq_done_o | output | 4 | Per-stream done interrupt |
| irq_err_o | output | 4 | Per-stream error interrupt |

## Verification
The main data path is run as a memory-to-memory transfer on stream 3. The runs cover source and destination size pairs that widen, narrow, match and differ by a factor of two, together with an odd byte count and counts of exactly one burst and more than one burst. Any mistake in byte order, packing lanes or burst length shows up as wrong destination bytes or a wrong end address. A peripheral stream with a fixed source separates fixed addressing from incrementing addressing. Two streams requesting at the same moment, and a request from stream 0 that arrives during a memory-to-memory burst, show whether priority is fixed and whether bursts are kept whole. An address that returns an error response tests the error path and the stop that follows it.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  localparam int NSTR = 4;

  typedef struct packed {
    logic       m2m;
    logic       dinc;
    logic       sinc;
    logic [1:0] dsz;
    logic [1:0] ssz;
    logic       en;
  } ctrl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} st_e;

  function automatic logic [2:0] sz_bytes(input logic [1:0] code);
    case (code)
      2'd0:    sz_bytes = 3'd1;
      2'd1:    sz_bytes = 3'd2;
      default: sz_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dma4_arb.sv
module dma4_arb #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  always_comb begin
    gnt_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req_i[i]) gnt_o = N'(1) << i;
  end

  a_r4_gnt_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  for (genvar i = 1; i < N; i++) begin : g_prio
    a_r4_gnt_highest: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_o[i] |-> (req_i[i] && req_i[i-1:0] == '0));
  end
endmodule

// File: rtl/dma4_fifo.sv
module dma4_fifo #(
  parameter int WORDS = 16,
  localparam int NB = 4 * WORDS,
  localparam int IW = $clog2(NB),
  localparam int PW = IW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [2:0]    push_n_i,
  input  logic [31:0]   push_d_i,
  input  logic          pop_i,
  input  logic [2:0]    pop_n_i,
  output logic [31:0]   head_o,
  output logic [PW-1:0] level_o
);
  logic [7:0]    mem [NB];
  logic [IW-1:0] wp, rp;

  always_ff @(posedge clk_i) begin
    if (push_i)
      for (int k = 0; k < 4; k++)
        if (3'(k) < push_n_i) mem[wp + IW'(k)] <= push_d_i[8*k +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp <= '0; rp <= '0; level_o <= '0;
    end else if (clr_i) begin
      wp <= '0; rp <= '0; level_o <= '0;
    end else begin
      if (push_i) wp <= wp + IW'(push_n_i);
      if (pop_i)  rp <= rp + IW'(pop_n_i);
      level_o <= level_o + (push_i ? PW'(push_n_i) : '0) - (pop_i ? PW'(pop_n_i) : '0);
    end
  end

  always_comb begin
    head_o = '0;
    for (int k = 0; k < 4; k++)
      if (3'(k) < pop_n_i) head_o[8*k +: 8] = mem[rp + IW'(k)];
  end

  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> ({1'b0, level_o} + (PW+1)'(push_n_i)) <= (PW+1)'(NB));
  a_r6_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> level_o >= PW'(pop_n_i));
endmodule

// File: rtl/dma4_chan.sv
module dma4_chan
  import dma4_pkg::*;
#(
  parameter int IDX = 0,
  parameter int AW  = 32,
  parameter int CW  = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [2:0]    sel_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic          upd_i,
  input  logic [AW-1:0] upd_src_i,
  input  logic [AW-1:0] upd_dst_i,
  input  logic [CW-1:0] upd_rem_i,
  input  logic          upd_done_i,
  input  logic          upd_err_i,
  output ctrl_t         ctrl_o,
  output logic [AW-1:0] cur_src_o,
  output logic [AW-1:0] cur_dst_o,
  output logic [CW-1:0] rem_o,
  output logic [1:0]    stat_o
);
  localparam bit HAS_M2M = (IDX == 3);

  logic [AW-1:0] src_q, dst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0; dst_q <= '0; rem_o <= '0; ctrl_o <= '0;
      stat_o <= '0; cur_src_o <= '0; cur_dst_o <= '0;
    end else begin
      if (wr_i) begin
        case (sel_i)
          3'd0: src_q <= wdata_i[AW-1:0];
          3'd1: dst_q <= wdata_i[AW-1:0];
          3'd2: rem_o <= wdata_i[CW-1:0];
          3'd3: begin
            ctrl_o <= ctrl_t'(wdata_i[7:0]);
            if (!HAS_M2M) ctrl_o.m2m <= 1'b0;
            if (wdata_i[0]) begin
              cur_src_o <= src_q;
              cur_dst_o <= dst_q;
            end
          end
          3'd4: stat_o <= stat_o & ~wdata_i[1:0];
          default: ;
        endcase
      end
      if (upd_i) begin
        cur_src_o <= upd_src_i;
        cur_dst_o <= upd_dst_i;
        rem_o     <= upd_rem_i;
        if (upd_done_i) begin ctrl_o.en <= 1'b0; stat_o[0] <= 1'b1; end
        if (upd_err_i)  begin ctrl_o.en <= 1'b0; stat_o[1] <= 1'b1; end
      end
    end
  end

  always_comb begin
    case (sel_i)
      3'd0:    rdata_o = 32'(src_q);
      3'd1:    rdata_o = 32'(dst_q);
      3'd2:    rdata_o = 32'(rem_o);
      3'd3:    rdata_o = 32'(ctrl_o);
      3'd4:    rdata_o = 32'(stat_o);
      3'd5:    rdata_o = 32'(cur_src_o);
      3'd6:    rdata_o = 32'(cur_dst_o);
      default: rdata_o = '0;
    endcase
  end

  a_r8_done_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && upd_done_i && !wr_i) |=> (!ctrl_o.en && stat_o[0]));
  a_r9_err_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && upd_err_i && !wr_i) |=> (!ctrl_o.en && stat_o[1]));
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma4_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int FIFO_WORDS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic [4:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic [3:0]    dreq_i,
  output logic          m_req_o,
  output logic          m_we_o,
  output logic [AW-1:0] m_addr_o,
  output logic [1:0]    m_size_o,
  output logic [31:0]   m_wdata_o,
  input  logic [31:0]   m_rdata_i,
  input  logic          m_ack_i,
  input  logic          m_err_i,
  output logic [3:0]    irq_done_o,
  output logic [3:0]    irq_err_o
);
  localparam int FB = 4 * FIFO_WORDS;
  localparam int PW = $clog2(FB) + 1;

  ctrl_t         ctrl_a [NSTR];
  logic [AW-1:0] cs_a [NSTR], cd_a [NSTR];
  logic [CW-1:0] rem_a [NSTR];
  logic [1:0]    stat_a [NSTR];
  logic [31:0]   rd_a [NSTR];
  logic [NSTR-1:0] elig, gnt;

  st_e           st;
  logic [1:0]    cur, gidx;
  logic [AW-1:0] a_src, a_dst, a_dst_nx;
  logic [PW-1:0] burst, rd_left, wr_left, burst_nx, lvl;
  ctrl_t         cc;
  logic [2:0]    sn, dn;
  logic          upd_any, upd_done, ok_ack;
  logic [CW-1:0] upd_rem;

  assign cc = ctrl_a[cur];
  assign sn = sz_bytes(cc.ssz);
  assign dn = sz_bytes(cc.dsz);
  assign ok_ack = m_ack_i && !m_err_i;

  assign m_req_o  = (st != ST_IDLE);
  assign m_we_o   = (st == ST_WR);
  assign m_addr_o = m_we_o ? a_dst : a_src;
  assign m_size_o = m_we_o ? cc.dsz : cc.ssz;

  assign a_dst_nx = a_dst + (cc.dinc ? AW'(dn) : '0);
  assign upd_any  = m_req_o && (m_err_i || (m_we_o && m_ack_i && wr_left == PW'(dn)));
  assign upd_done = !m_err_i && (rem_a[cur] == CW'(burst));
  assign upd_rem  = m_err_i ? rem_a[cur] : rem_a[cur] - CW'(burst);

  always_comb begin
    gidx = '0;
    for (int i = 0; i < NSTR; i++)
      if (gnt[i]) gidx = 2'(i);
  end
  assign burst_nx = (rem_a[gidx] >= CW'(FB)) ? PW'(FB) : PW'(rem_a[gidx]);
  assign reg_rdata_o = rd_a[reg_addr_i[4:3]];

  for (genvar i = 0; i < NSTR; i++) begin : g_str
    dma4_chan #(.IDX(i), .AW(AW), .CW(CW)) u_chan (
      .clk_i, .rst_ni,
      .wr_i       (reg_wr_i && reg_addr_i[4:3] == 2'(i)),
      .sel_i      (reg_addr_i[2:0]),
      .wdata_i    (reg_wdata_i),
      .rdata_o    (rd_a[i]),
      .upd_i      (upd_any && cur == 2'(i)),
      .upd_src_i  (a_src),
      .upd_dst_i  (m_err_i ? a_dst : a_dst_nx),
      .upd_rem_i  (upd_rem),
      .upd_done_i (upd_done),
      .upd_err_i  (m_err_i),
      .ctrl_o     (ctrl_a[i]),
      .cur_src_o  (cs_a[i]),
      .cur_dst_o  (cd_a[i]),
      .rem_o      (rem_a[i]),
      .stat_o     (stat_a[i])
    );
    assign elig[i]       = ctrl_a[i].en && rem_a[i] != '0 && (dreq_i[i] || ctrl_a[i].m2m);
    assign irq_done_o[i] = stat_a[i][0];
    assign irq_err_o[i]  = stat_a[i][1];
  end

  dma4_arb #(.N(NSTR)) u_arb (.clk_i, .rst_ni, .req_i(elig), .gnt_o(gnt));

  dma4_fifo #(.WORDS(FIFO_WORDS)) u_fifo (
    .clk_i, .rst_ni,
    .clr_i    (st == ST_IDLE),
    .push_i   (st == ST_RD && ok_ack),
    .push_n_i (sn),
    .push_d_i (m_rdata_i),
    .pop_i    (st == ST_WR && ok_ack),
    .pop_n_i  (dn),
    .head_o   (m_wdata_o),
    .level_o  (lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE; cur <= '0; a_src <= '0; a_dst <= '0;
      burst <= '0; rd_left <= '0; wr_left <= '0;
    end else begin
      case (st)
        ST_IDLE: if (|gnt) begin
          cur     <= gidx;
          a_src   <= cs_a[gidx];
          a_dst   <= cd_a[gidx];
          burst   <= burst_nx;
          rd_left <= burst_nx;
          wr_left <= burst_nx;
          st      <= ST_RD;
        end
        ST_RD: if (m_err_i) st <= ST_IDLE;
          else if (m_ack_i) begin
            a_src   <= a_src + (cc.sinc ? AW'(sn) : '0);
            rd_left <= rd_left - PW'(sn);
            if (rd_left == PW'(sn)) st <= ST_WR;
          end
        ST_WR: if (m_err_i) st <= ST_IDLE;
          else if (m_ack_i) begin
            a_dst   <= a_dst_nx;
            wr_left <= wr_left - PW'(dn);
            if (wr_left == PW'(dn)) st <= ST_IDLE;
          end
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r12_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_req_o && !m_ack_i && !m_err_i) |=> (m_req_o && $stable(m_addr_o) && $stable(m_we_o) && $stable(m_size_o)));
  a_r7_reads_before_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_we_o && !upd_any) |=> (m_we_o || !m_req_o));
  a_r7_write_phase_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(m_we_o) |-> lvl == burst);
endmodule

// File: tb/dma4_ctrl_bench.sv
module dma4_ctrl_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [3:0]  dreq = '0;
  logic        m_req, m_we, m_ack = 1'b0, m_err = 1'b0;
  logic [31:0] m_addr, m_wdata, m_rdata = '0;
  logic [1:0]  m_size;
  logic [3:0]  irq_done, irq_err;

  always #10 clk = ~clk;

  dma4_ctrl u_dma4_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .dreq_i(dreq),
    .m_req_o(m_req), .m_we_o(m_we), .m_addr_o(m_addr), .m_size_o(m_size),
    .m_wdata_o(m_wdata), .m_rdata_i(m_rdata), .m_ack_i(m_ack), .m_err_i(m_err),
    .irq_done_o(irq_done), .irq_err_o(irq_err)
  );

  logic [7:0]  mem [0:1023];
  logic [31:0] wlog [0:255];
  logic [7:0]  wn = '0;
  int checks = 0, errors = 0;

  // bus slave: one-cycle response; address bit 12 gives an error
  always @(posedge clk) begin
    m_ack <= 1'b0; m_err <= 1'b0;
    if (m_req && !m_ack && !m_err) begin
      if (m_addr[12]) m_err <= 1'b1;
      else begin
        m_ack <= 1'b1;
        if (m_we) begin
          for (int k = 0; k < 4; k++)
            if (k < (m_size == 0 ? 1 : m_size == 1 ? 2 : 4))
              mem[m_addr[9:0] + 10'(k)] <= m_wdata[8*k +: 8];
          wlog[wn] <= m_addr;
          wn <= wn + 8'd1;
        end else begin
          m_rdata <= '0;
          for (int k = 0; k < 4; k++)
            if (k < (m_size == 0 ? 1 : m_size == 1 ? 2 : 4))
              m_rdata[8*k +: 8] <= mem[m_addr[9:0] + 10'(k)];
        end
      end
    end
  end

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 13 + 7);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int s, input int r, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'((s << 3) | r); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int s, input int r, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 5'((s << 3) | r);
    #1 d = reg_rdata;
  endtask

  task automatic wait_irq(input int s, input bit err);
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      if (err ? irq_err[s] : irq_done[s]) break;
    end
  endtask

  function automatic logic [31:0] cw(input bit m2m, input bit di, input bit si,
                                     input logic [1:0] ds, input logic [1:0] ss);
    return {24'd0, m2m, di, si, ds, ss, 1'b1};
  endfunction

  // {src size, dst size, byte count}
  localparam logic [19:0] VECS [7] = '{
    {2'd0, 2'd2, 16'd8},  {2'd2, 2'd0, 16'd8},  {2'd1, 2'd2, 16'd12},
    {2'd2, 2'd1, 16'd16}, {2'd0, 2'd0, 16'd5},  {2'd1, 2'd1, 16'd64},
    {2'd2, 2'd2, 16'd80}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int bad;
    logic [7:0] base;
    for (int a = 0; a < 1024; a++) mem[a] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3, 3, d); chk("R1 ctrl reset", d, 0);
    rd(3, 4, d); chk("R1 stat reset", d, 0);
    rd(0, 2, d); chk("R1 count reset", d, 0);
    chk("R1 no request / irqs", {m_req, irq_done, irq_err}, 0);

    // R2 readback
    wr(1, 0, 32'h0000_1234); wr(1, 1, 32'h0000_0ABC); wr(1, 2, 32'h0000_0042);
    rd(1, 0, d); chk("R2 src", d, 32'h1234);
    rd(1, 1, d); chk("R2 dst", d, 32'h0ABC);
    rd(1, 2, d); chk("R2 count", d, 32'h42);
    wr(1, 2, 0);

    // R10 / R3: m2m bit ignored on stream 0, no request without dreq
    wr(0, 0, 32'h300); wr(0, 1, 32'h3C0); wr(0, 2, 4);
    wr(0, 3, cw(1, 1, 0, 2, 2));
    rd(0, 3, d); chk("R10 m2m bit reads zero on stream 0", d[7], 1'b0);
    bad = 0;
    for (int n = 0; n < 20; n++) begin @(negedge clk); if (m_req) bad++; end
    chk("R3 R10 no request without dreq", bad, 0);
    wr(0, 3, 0); wr(0, 2, 0);

    // R5 R6 R7 R8 R11: memory-to-memory size table on stream 3
    for (int v = 0; v < 7; v++) begin
      int cnt;
      cnt = int'(VECS[v][15:0]);
      for (int a = 0; a < 256; a++) begin mem[256 + a] = pat(a); mem[512 + a] = 8'h00; end
      wr(3, 0, 32'h100); wr(3, 1, 32'h200); wr(3, 2, cnt);
      wr(3, 3, cw(1, 1, 1, VECS[v][17:16], VECS[v][19:18]));
      wait_irq(3, 0);
      bad = 0;
      for (int a = 0; a < cnt; a++) if (mem[512 + a] !== pat(a)) bad++;
      chk($sformatf("R6 vec%0d byte order mismatches", v), bad, 0);
      chk($sformatf("R7 vec%0d byte past count", v), mem[512 + cnt], 8'h00);
      rd(3, 5, d); chk($sformatf("R11 vec%0d cur src", v), d, 32'h100 + cnt);
      rd(3, 6, d); chk($sformatf("R11 vec%0d cur dst", v), d, 32'h200 + cnt);
      rd(3, 4, d); chk($sformatf("R8 vec%0d done status", v), d, 1);
      rd(3, 3, d); chk($sformatf("R8 vec%0d enable cleared", v), d[0], 1'b0);
      wr(3, 4, 1);
      @(negedge clk); chk($sformatf("R8 vec%0d irq cleared", v), irq_done[3], 1'b0);
    end

    // R5 R11: fixed peripheral source, byte reads packed into words
    mem[768] = 8'h5A;
    wr(1, 0, 32'h300); wr(1, 1, 32'h340); wr(1, 2, 8);
    wr(1, 3, cw(0, 1, 0, 2, 0));
    @(negedge clk); dreq[1] = 1'b1;
    wait_irq(1, 0); dreq[1] = 1'b0;
    bad = 0;
    for (int a = 0; a < 8; a++) if (mem[832 + a] !== 8'h5A) bad++;
    chk("R5 fixed source fill", bad, 0);
    rd(1, 5, d); chk("R5 R11 fixed source address kept", d, 32'h300);
    wr(1, 4, 1);

    // R4: streams 1 and 2 request together
    wr(1, 0, 32'h300); wr(1, 1, 32'h3D0); wr(1, 2, 4); wr(1, 3, cw(0, 1, 0, 2, 2));
    wr(2, 0, 32'h300); wr(2, 1, 32'h3E0); wr(2, 2, 4); wr(2, 3, cw(0, 1, 0, 2, 2));
    base = wn;
    @(negedge clk); dreq[2:1] = 2'b11;
    wait_irq(1, 0); wait_irq(2, 0); dreq = '0;
    chk("R4 stream 1 before stream 2", wlog[base], 32'h3D0);
    chk("R4 stream 2 second", wlog[base + 8'd1], 32'h3E0);
    wr(1, 4, 1); wr(2, 4, 1);

    // R4 R7: stream 0 request during a memory-to-memory burst of stream 3
    wr(0, 0, 32'h300); wr(0, 1, 32'h3C0); wr(0, 2, 4); wr(0, 3, cw(0, 1, 0, 2, 2));
    wr(3, 0, 32'h000); wr(3, 1, 32'h080); wr(3, 2, 128);
    base = wn;
    wr(3, 3, cw(1, 1, 1, 2, 2));
    repeat (3) @(negedge clk);
    dreq[0] = 1'b1;
    wait_irq(0, 0); dreq[0] = 1'b0;
    wait_irq(3, 0);
    chk("R7 first burst kept whole", wlog[base + 8'd15], 32'h0BC);
    chk("R4 stream 0 granted at burst boundary", wlog[base + 8'd16], 32'h3C0);
    chk("R4 stream 3 resumes", wlog[base + 8'd17], 32'h0C0);
    wr(0, 4, 1); wr(3, 4, 1);

    // R9: error response
    wr(2, 0, 32'h1000); wr(2, 1, 32'h3E0); wr(2, 2, 8); wr(2, 3, cw(0, 1, 1, 2, 2));
    @(negedge clk); dreq[2] = 1'b1;
    wait_irq(2, 1);
    rd(2, 4, d); chk("R9 error status", d, 2);
    rd(2, 3, d); chk("R9 enable cleared", d[0], 1'b0);
    bad = 0;
    for (int n = 0; n < 20; n++) begin @(negedge clk); if (m_req) bad++; end
    chk("R9 no request after error", bad, 0);
    wr(2, 4, 2);
    @(negedge clk); chk("R9 error irq cleared", irq_err[2], 1'b0);
    dreq = '0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule